// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a small set of recent page translations and converts a virtual byte address into a physical byte address. Pages are 4 KB, so the low twelve address bits are passed through untouched while the virtual page number above them is compared against every stored entry in parallel. When one entry matches, the block returns that entry's physical page number joined to the page offset, in the same cycle as the request. When no entry matches, it raises a miss. An external handler then looks up the page table, installs the translation through the fill port and retries the access.

Each entry keeps two status flags. A use flag is set every time the entry translates an access, and a modified flag is set when the access is a store. A clear input zeroes all use flags without touching anything else, and a flush input invalidates every entry. Replacement keeps a full recency order across the entries. A fill goes to an entry that already holds the same page, otherwise to the lowest-numbered empty entry, otherwise to the least recently used one. The entry the next fill will write is shown on an output at all times.

Top module: `tlb_fa`

## Requirements
- R1: After reset no entry is valid: every lookup misses and `fill_slot` reads 0.
- R2: A lookup whose page number matches a valid entry asserts `lk_hit` in the same cycle, `lk_paddr` equals that entry's physical page number in bits 31:12 with `lk_vaddr[11:0]` in bits 11:0, and `lk_slot` gives the entry index.
- R3: A lookup with no matching valid entry asserts `lk_miss` and not `lk_hit`, and `lk_paddr` carries zeros in bits 31:12 with the page offset below.
- R4: A freshly filled entry reports `lk_ref` = 0. Every hit sets that entry's use flag, and later lookups of it report `lk_ref` = 1.
- R5: A hit with `lk_store` = 1 sets the entry's modified flag, which later lookups report on `lk_dirty`. Hits with `lk_store` = 0 leave the flag unchanged, and a fill clears it.
- R6: When some entry is invalid and the fill page is not already present, the fill writes the lowest-numbered invalid entry.
- R7: When all entries are valid, a fill writes the entry least recently touched, where both hits and fills count as touches.
- R8: A fill whose page number is already held by a valid entry overwrites that entry in place, with a new physical page and both flags cleared.
- R9: A `ref_clear` pulse zeroes every use flag and leaves valid, page and modified state alone. A hit in the same cycle still sets its own entry's use flag.
- R10: A `flush` pulse invalidates all entries. A fill in the same cycle is dropped.
- R11: With `lk_valid` = 0, neither `lk_hit` nor `lk_miss` is raised, and no use flag or recency state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_store | input | 1 | Lookup is for a store access |
| lk_vaddr | input | 32 | Virtual byte address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent, handler must fill |
| lk_paddr | output | 32 | Translated physical byte address |
| lk_slot | output | 4 | Index of the matching entry |
| lk_ref | output | 1 | Use flag of the matching entry before this access |
| lk_dirty | output | 1 | Modified flag of the matching entry before this access |
| fill_en | input | 1 | Install a translation on this clock edge |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_slot | output | 4 | Entry the fill would write this cycle |
| ref_clear | input | 1 | Zero all use flags |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with its default values: sixteen entries, 32-bit virtual and physical addresses and 4 KB pages. With only sixteen entries the bench can fill the whole array from empty, and so reach the point where invalid-first selection hands over to recency replacement. It can also follow the exact recency order by hand through a short sequence of hits and fills. The full 20-bit page numbers keep the offset pass-through and the upper-bit zeroing on a miss clearly visible in the output address.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Bits of a byte address that lie inside one 4 KB page.
    localparam int unsigned PAGE_OFS_W = 12;

    // Per-lookup status gathered from the matching entry.
    typedef struct packed {
        logic hit;
        logic refd;
        logic dirty;
    } tlb_lk_flags_t;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int unsigned N     = 16,
    parameter int unsigned KEY_W = 20,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [KEY_W-1:0]        key,
    input  logic [N-1:0][KEY_W-1:0] tags,
    input  logic [N-1:0]            valid,
    output logic [N-1:0]            match,
    output logic                    any,
    output logic [IDX_W-1:0]        idx
);

    // One comparator per entry, all evaluated at once.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    assign any = |match;

    // Encode the lowest matching entry.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_age.sv
module tlb_age #(
    parameter int unsigned N     = 16,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_en,
    input  logic [IDX_W-1:0] a_idx,
    input  logic             b_en,
    input  logic [IDX_W-1:0] b_idx,
    output logic [IDX_W-1:0] lru_idx
);

    typedef logic [N-1:0][IDX_W-1:0] age_vec_t;

    age_vec_t ages_d, ages_q;

    // Move entry k to age 0; every entry that was younger ages by one.
    function automatic age_vec_t touch(input age_vec_t a, input logic [IDX_W-1:0] k);
        age_vec_t r;
        r = a;
        for (int i = 0; i < N; i++) begin
            if (a[i] < a[k]) r[i] = a[i] + 1'b1;
        end
        r[k] = '0;
        return r;
    endfunction

    always_comb begin
        ages_d = ages_q;
        if (a_en) ages_d = touch(ages_d, a_idx);
        if (b_en) ages_d = touch(ages_d, b_idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ages_q[i] <= IDX_W'(i);
        end else begin
            ages_q <= ages_d;
        end
    end

    // The oldest entry carries the largest age.
    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (ages_q[i] == IDX_W'(N - 1)) lru_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int unsigned N     = 16,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid,
    input  logic             dup_any,
    input  logic [IDX_W-1:0] dup_idx,
    input  logic [IDX_W-1:0] lru_idx,
    output logic [IDX_W-1:0] slot
);

    logic             free_any;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    // Same page first, then an empty entry, then the oldest one.
    always_comb begin
        if (dup_any)       slot = dup_idx;
        else if (free_any) slot = free_idx;
        else               slot = lru_idx;
    end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int unsigned N    = 16,
    parameter int unsigned VA_W = 32,
    parameter int unsigned PA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_valid,
    input  logic                       lk_store,
    input  logic [VA_W-1:0]            lk_vaddr,
    output logic                       lk_hit,
    output logic                       lk_miss,
    output logic [PA_W-1:0]            lk_paddr,
    output logic [$clog2(N)-1:0]       lk_slot,
    output logic                       lk_ref,
    output logic                       lk_dirty,
    input  logic                       fill_en,
    input  logic [VA_W-PAGE_OFS_W-1:0] fill_vpn,
    input  logic [PA_W-PAGE_OFS_W-1:0] fill_ppn,
    output logic [$clog2(N)-1:0]       fill_slot,
    input  logic                       ref_clear,
    input  logic                       flush
);

    localparam int unsigned IDX_W = $clog2(N);
    localparam int unsigned VPN_W = VA_W - PAGE_OFS_W;
    localparam int unsigned PPN_W = PA_W - PAGE_OFS_W;

    typedef struct packed {
        logic [N-1:0][VPN_W-1:0] vpn;
        logic [N-1:0][PPN_W-1:0] ppn;
        logic [N-1:0]            valid;
        logic [N-1:0]            refd;
        logic [N-1:0]            dirty;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [N-1:0]     lk_match, fl_match;
    logic             lk_any, fl_any;
    logic [IDX_W-1:0] lk_idx, fl_idx, lru_idx, pick_idx;
    logic             fill_go;
    tlb_lk_flags_t    lk_flags;

    tlb_cam #(.N(N), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_cam_lk (
        .key   (lk_vaddr[VA_W-1:PAGE_OFS_W]),
        .tags  (st_q.vpn),
        .valid (st_q.valid),
        .match (lk_match),
        .any   (lk_any),
        .idx   (lk_idx)
    );

    tlb_cam #(.N(N), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_cam_fill (
        .key   (fill_vpn),
        .tags  (st_q.vpn),
        .valid (st_q.valid),
        .match (fl_match),
        .any   (fl_any),
        .idx   (fl_idx)
    );

    tlb_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .valid   (st_q.valid),
        .dup_any (fl_any),
        .dup_idx (fl_idx),
        .lru_idx (lru_idx),
        .slot    (pick_idx)
    );

    assign fill_go = fill_en && !flush;

    tlb_age #(.N(N), .IDX_W(IDX_W)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_en    (lk_flags.hit),
        .a_idx   (lk_idx),
        .b_en    (fill_go),
        .b_idx   (pick_idx),
        .lru_idx (lru_idx)
    );

    // Lookup result, combinational from the stored entries.
    always_comb begin
        lk_flags.hit   = lk_valid && lk_any;
        lk_flags.refd  = lk_flags.hit && st_q.refd[lk_idx];
        lk_flags.dirty = lk_flags.hit && st_q.dirty[lk_idx];
    end

    assign lk_hit    = lk_flags.hit;
    assign lk_miss   = lk_valid && !lk_any;
    assign lk_ref    = lk_flags.refd;
    assign lk_dirty  = lk_flags.dirty;
    assign lk_slot   = lk_flags.hit ? lk_idx : '0;
    assign lk_paddr  = {(lk_flags.hit ? st_q.ppn[lk_idx] : {PPN_W{1'b0}}),
                        lk_vaddr[PAGE_OFS_W-1:0]};
    assign fill_slot = pick_idx;

    // Next state of the entry array.
    always_comb begin
        st_d = st_q;
        if (ref_clear) st_d.refd = '0;
        if (lk_flags.hit) begin
            st_d.refd[lk_idx] = 1'b1;
            if (lk_store) st_d.dirty[lk_idx] = 1'b1;
        end
        if (fill_go) begin
            st_d.vpn[pick_idx]   = fill_vpn;
            st_d.ppn[pick_idx]   = fill_ppn;
            st_d.valid[pick_idx] = 1'b1;
            st_d.refd[pick_idx]  = 1'b0;
            st_d.dirty[pick_idx] = 1'b0;
        end
        if (flush) st_d.valid = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int unsigned VA_W = 32,
    parameter int unsigned PA_W = 32,
    parameter int unsigned OFS  = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lk_valid,
    input logic                lk_store,
    input logic [VA_W-1:0]     lk_vaddr,
    input logic                lk_hit,
    input logic                lk_miss,
    input logic [PA_W-1:0]     lk_paddr,
    input logic                lk_ref,
    input logic                lk_dirty,
    input logic                fill_en,
    input logic [VA_W-OFS-1:0] fill_vpn,
    input logic [PA_W-OFS-1:0] fill_ppn,
    input logic                ref_clear,
    input logic                flush
);

    assert_one_outcome_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> $countones({lk_hit, lk_miss}) == 1);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));

    assert_fill_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fill_en && !flush) && lk_valid &&
         lk_vaddr[VA_W-1:OFS] == $past(fill_vpn))
        |-> (lk_hit && lk_paddr[PA_W-1:OFS] == $past(fill_ppn) &&
             lk_paddr[OFS-1:0] == lk_vaddr[OFS-1:0]));

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flush)) |-> !lk_hit);

    assert_ref_sticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lk_hit && !fill_en && !flush) && lk_valid &&
         lk_vaddr[VA_W-1:OFS] == $past(lk_vaddr[VA_W-1:OFS]))
        |-> (lk_hit && lk_ref));

    assert_store_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lk_hit && lk_store && !fill_en && !flush) && lk_valid &&
         lk_vaddr[VA_W-1:OFS] == $past(lk_vaddr[VA_W-1:OFS]))
        |-> (lk_hit && lk_dirty));

    assert_clear_refs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ref_clear && !lk_valid)) |-> !lk_ref);

endmodule

bind tlb_fa tlb_fa_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFS(tlb_pkg::PAGE_OFS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_store  (lk_store),
    .lk_vaddr  (lk_vaddr),
    .lk_hit    (lk_hit),
    .lk_miss   (lk_miss),
    .lk_paddr  (lk_paddr),
    .lk_ref    (lk_ref),
    .lk_dirty  (lk_dirty),
    .fill_en   (fill_en),
    .fill_vpn  (fill_vpn),
    .fill_ppn  (fill_ppn),
    .ref_clear (ref_clear),
    .flush     (flush)
);

// File: tb/sim_tlb_fa.sv
module sim_tlb_fa;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_store = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss, lk_ref, lk_dirty;
    logic [31:0] lk_paddr;
    logic [3:0]  lk_slot, fill_slot;
    logic        fill_en = 1'b0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic        ref_clear = 1'b0, flush = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tlb_fa u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_store(lk_store), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .lk_slot(lk_slot), .lk_ref(lk_ref), .lk_dirty(lk_dirty),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_slot(fill_slot), .ref_clear(ref_clear), .flush(flush)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Inputs change 1 ns after a rising edge; checks land mid-cycle.
    task automatic look(input logic [31:0] va, input logic st, input logic e_hit,
                        input logic [19:0] e_ppn, input logic e_ref, input logic e_dirty,
                        input int e_slot, input string req);
        lk_valid = 1'b1; lk_vaddr = va; lk_store = st;
        #1;
        chk(req, "hit", 32'(lk_hit), 32'(e_hit));
        chk(req, "miss", 32'(lk_miss), 32'(!e_hit));
        chk(req, "paddr", lk_paddr, {(e_hit ? e_ppn : 20'h0), va[11:0]});
        if (e_hit) begin
            chk(req, "ref", 32'(lk_ref), 32'(e_ref));
            chk(req, "dirty", 32'(lk_dirty), 32'(e_dirty));
            if (e_slot >= 0) chk(req, "slot", 32'(lk_slot), 32'(e_slot));
        end
        @(posedge clk); #1;
        lk_valid = 1'b0; lk_store = 1'b0;
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn);
        fill_en = 1'b1; fill_vpn = vpn; fill_ppn = ppn;
        @(posedge clk); #1;
        fill_en = 1'b0;
    endtask

    task automatic slot_is(input logic [19:0] vpn, input int e, input string req);
        fill_vpn = vpn;
        #1;
        chk(req, "fill_slot", 32'(fill_slot), 32'(e));
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(posedge clk); #1;
        flush = 1'b0;
    endtask

    task automatic t_reset();
        look(32'h0000_0123, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, -1, "R1");
        slot_is(20'h00000, 0, "R1");
    endtask

    task automatic t_basic();
        fill(20'h12345, 20'hABCDE);
        // R11: an idle request raises nothing and leaves the use flag clear
        lk_vaddr = 32'h1234_5678; lk_valid = 1'b0;
        #1;
        chk("R11", "idle hit", 32'(lk_hit), 32'h0);
        chk("R11", "idle miss", 32'(lk_miss), 32'h0);
        @(posedge clk); #1;
        look(32'h1234_5678, 1'b0, 1'b1, 20'hABCDE, 1'b0, 1'b0, 0, "R2");
        look(32'h1234_5FFF, 1'b0, 1'b1, 20'hABCDE, 1'b1, 1'b0, 0, "R4");
        look(32'h5432_1ABC, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, -1, "R3");
    endtask

    task automatic t_dirty();
        look(32'h1234_5000, 1'b0, 1'b1, 20'hABCDE, 1'b1, 1'b0, 0, "R5");
        look(32'h1234_5004, 1'b1, 1'b1, 20'hABCDE, 1'b1, 1'b0, 0, "R5");
        look(32'h1234_5008, 1'b0, 1'b1, 20'hABCDE, 1'b1, 1'b1, 0, "R5");
    endtask

    task automatic t_free_first();
        pulse_flush();
        for (int i = 0; i < 3; i++) begin
            slot_is(20'h00300 + 20'(i), i, "R6");
            fill(20'h00300 + 20'(i), 20'h00400 + 20'(i));
        end
    endtask

    task automatic t_lru();
        pulse_flush();
        for (int i = 0; i < 16; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i));
        slot_is(20'h00999, 0, "R7");
        look(32'h0010_0010, 1'b0, 1'b1, 20'h00200, 1'b0, 1'b0, 0, "R7");
        slot_is(20'h00999, 1, "R7");
        // R11: idle request on entry 1 must not refresh its age
        lk_vaddr = 32'h0010_1000; lk_valid = 1'b0;
        @(posedge clk); #1;
        slot_is(20'h00999, 1, "R11");
        fill(20'h00999, 20'h009AA);
        look(32'h0099_9321, 1'b0, 1'b1, 20'h009AA, 1'b0, 1'b0, 1, "R7");
        look(32'h0010_1000, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, -1, "R7");
        slot_is(20'h00998, 2, "R7");
    endtask

    task automatic t_dup();
        look(32'h0010_5000, 1'b1, 1'b1, 20'h00205, 1'b0, 1'b0, 5, "R8");
        slot_is(20'h00105, 5, "R8");
        fill(20'h00105, 20'h00777);
        look(32'h0010_5ABC, 1'b0, 1'b1, 20'h00777, 1'b0, 1'b0, 5, "R8");
    endtask

    task automatic t_clear();
        look(32'h0010_6000, 1'b1, 1'b1, 20'h00206, 1'b0, 1'b0, 6, "R9");
        ref_clear = 1'b1;
        @(posedge clk); #1;
        ref_clear = 1'b0;
        look(32'h0010_6010, 1'b0, 1'b1, 20'h00206, 1'b0, 1'b1, 6, "R9");
        ref_clear = 1'b1;
        look(32'h0010_7000, 1'b0, 1'b1, 20'h00207, 1'b0, 1'b0, 7, "R9");
        ref_clear = 1'b0;
        look(32'h0010_7000, 1'b0, 1'b1, 20'h00207, 1'b1, 1'b0, 7, "R9");
        look(32'h0010_6020, 1'b0, 1'b1, 20'h00206, 1'b0, 1'b1, 6, "R9");
    endtask

    task automatic t_flush();
        flush = 1'b1;
        fill(20'h00555, 20'h00666);
        flush = 1'b0;
        look(32'h0055_5000, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, -1, "R10");
        look(32'h0010_6000, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0, -1, "R10");
        slot_is(20'h00555, 0, "R10");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_basic();
        t_dirty();
        t_free_first();
        t_lru();
        t_dup();
        t_clear();
        t_flush();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule